// File: doc/BRIEF.md
# Paged SRAM Byte Cursor

This block gives a host sequential byte access to an external synchronous SRAM without ever exposing a full byte address. The host selects a 32-byte page through a 16-bit page number, split into a high and a low byte. A hidden cursor then points at byte 0 of that page. Every byte moved through the data port, whether read or written, uses the cursor and then steps it forward by one. Long transfers can therefore run across page boundaries without any further setup.

Reading the page number back returns the page the cursor is in now. The position inside the page cannot be seen. While the power-save input is high, writes to the SRAM are suppressed. The suppressed bytes still consume a cursor position, so a stream of bytes stays aligned with its addresses. The installed SRAM size is set by a parameter in units of 128 KB, from 1 to 16 units. All addresses wrap modulo that size.

Top module: `sram_page_cursor`

## Requirements
- R1: After reset the cursor is 0, both page readback bytes read 0, `rsp_valid` is low and `sram_en` is low.
- R2: A write with `pg_wr_sel`=1 (high page byte) only stores that byte for later use. The cursor, and therefore `sram_addr` and the page readback, are unchanged.
- R3: A write with `pg_wr_sel`=0 (low page byte) loads the cursor with page {stored high byte, written low byte}, offset 0. `req_ready` is low in that cycle, and the next access uses the new address.
- R4: Each accepted data access (`req_valid` and `req_ready` high at a clock edge) advances the cursor by exactly one byte. Reads and writes share the same cursor.
- R5: `pg_rd_data` returns bits 20:13 of the cursor when `pg_rd_sel`=1 and bits 12:5 when `pg_rd_sel`=0. After a transfer crosses a page boundary it therefore shows the new page.
- R6: From the last byte of the configured size, the cursor steps to address 0.
- R7: An accepted read drives `sram_en`=1, `sram_we`=0 and `sram_addr`=cursor in the same cycle. `rsp_valid` is high in the next cycle, with `rsp_rdata` equal to the SRAM's data for that address.
- R8: An accepted write with `power_save` low drives `sram_en`=1, `sram_we`=1, `sram_addr`=cursor and `sram_wdata`=`req_wdata` in the same cycle.
- R9: An accepted write with `power_save` high leaves `sram_en` low, so memory is untouched, but it still advances the cursor. Reads work as usual in power save.
- R10: A loaded page address of page×32 that is at or beyond the configured size is reduced modulo the size.
- R11: With no accepted access, `sram_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| power_save | input | 1 | High suppresses SRAM writes |
| pg_wr_en | input | 1 | Page byte write strobe |
| pg_wr_sel | input | 1 | 1 = high page byte, 0 = low page byte (loads cursor) |
| pg_wr_data | input | 8 | Page byte value |
| pg_rd_sel | input | 1 | Selects readback byte: 1 = high, 0 = low |
| pg_rd_data | output | 8 | Current page byte of the cursor |
| req_valid | input | 1 | Data access request |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 8 | Read data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 21 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, valid the cycle after a read enable |

## Verification
The bench builds the block with `SIZE_UNITS`=1, a 128 KB space of 4096 pages. At that size a directed pass of 32 writes reaches the wrap from the last byte back to address 0. Page numbers with high bits set, such as 0x1234, exercise the modulo reduction of an out-of-range page load. Random mixes of page loads, reads, writes and power-save writes are checked against a bench model of the cursor and of the memory contents.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int ADDR_W     = 21;
  localparam int PAGE_W     = 16;
  localparam int OFF_W      = 5;
  localparam int BYTE_W     = 8;
  localparam int UNIT_BYTES = 131072;
endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/spc_pointer.sv
module spc_pointer
  import spc_pkg::*;
#(
  parameter int MEM_BYTES = UNIT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              step,
  output logic [ADDR_W-1:0] cursor
);
  localparam logic [ADDR_W:0]   SIZE_W = (ADDR_W+1)'(MEM_BYTES);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(MEM_BYTES - 1);

  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W:0]   seed;
  logic [ADDR_W:0]   seed_mod;

  always_comb begin
    seed     = {1'b0, hi_q, wr_byte, {OFF_W{1'b0}}};
    seed_mod = seed % SIZE_W;
    hi_d     = hi_q;
    cur_d    = cur_q;
    if (hi_wr) hi_d = wr_byte;
    if (lo_wr)
      cur_d = seed_mod[ADDR_W-1:0];
    else if (step)
      cur_d = (cur_q == LAST) ? '0 : cur_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      cur_q <= '0;
    end else begin
      if (hi_wr)         hi_q  <= hi_d;
      if (lo_wr || step) cur_q <= cur_d;
    end
  end

  assign cursor = cur_q;
endmodule

// File: rtl/spc_port.sv
module spc_port
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_stall,
  input  logic              power_save,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              step,
  output logic              sram_en,
  output logic              sram_we,
  output logic [BYTE_W-1:0] sram_wdata,
  output logic              rsp_valid
);
  logic rsp_q, rsp_d;
  logic write_blocked;

  always_comb begin
    req_ready     = run && !load_stall;
    step          = req_valid && req_ready;
    write_blocked = req_write && power_save;
    sram_en       = step && !write_blocked;
    sram_we       = step && req_write && !power_save;
    sram_wdata    = req_wdata;
    rsp_d         = step && !req_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q;
endmodule

// File: rtl/sram_page_cursor.sv
module sram_page_cursor
  import spc_pkg::*;
#(
  parameter int SIZE_UNITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_save,
  input  logic              pg_wr_en,
  input  logic              pg_wr_sel,
  input  logic [BYTE_W-1:0] pg_wr_data,
  input  logic              pg_rd_sel,
  output logic [BYTE_W-1:0] pg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [BYTE_W-1:0] sram_wdata,
  input  logic [BYTE_W-1:0] sram_rdata
);
  localparam int MEM_BYTES = SIZE_UNITS * UNIT_BYTES;

  logic rst_sync_n;
  logic hi_wr, lo_wr, step;
  logic [ADDR_W-1:0] cursor;

  spc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    hi_wr = pg_wr_en && pg_wr_sel && rst_sync_n;
    lo_wr = pg_wr_en && !pg_wr_sel && rst_sync_n;
  end

  spc_pointer #(.MEM_BYTES(MEM_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .wr_byte(pg_wr_data), .step(step), .cursor(cursor)
  );

  spc_port u_port (
    .clk(clk), .rst_n(rst_sync_n), .run(rst_sync_n), .load_stall(lo_wr),
    .power_save(power_save), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .req_ready(req_ready), .step(step),
    .sram_en(sram_en), .sram_we(sram_we), .sram_wdata(sram_wdata),
    .rsp_valid(rsp_valid)
  );

  assign sram_addr  = cursor;
  assign rsp_rdata  = sram_rdata;
  assign pg_rd_data = pg_rd_sel ? cursor[ADDR_W-1 -: BYTE_W] : cursor[OFF_W +: BYTE_W];
endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
#(
  parameter int SIZE_UNITS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              power_save,
  input logic              pg_wr_en,
  input logic              pg_wr_sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              sram_en,
  input logic              sram_we,
  input logic [ADDR_W-1:0] sram_addr
);
  localparam int MEM_BYTES = SIZE_UNITS * UNIT_BYTES;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_BYTES - 1);
  localparam logic [ADDR_W:0]   SIZE_W = (ADDR_W+1)'(MEM_BYTES);

  logic acc;
  assign acc = req_valid && req_ready;

  p_stall_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr_en && !pg_wr_sel) |-> !req_ready);

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (sram_addr == (($past(sram_addr) == LAST) ? '0 : $past(sram_addr) + 1'b1)));

  p_hi_keeps_cursor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr_en && pg_wr_sel && !acc) |=> $stable(sram_addr));

  p_addr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sram_addr} < SIZE_W));

  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  p_rsp_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$rose(rst_n)) |-> $past(acc && !req_write));

  p_no_write_in_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    power_save |-> !(sram_en && sram_we));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> !sram_en);
endmodule

bind sram_page_cursor spc_checker #(.SIZE_UNITS(SIZE_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .power_save(power_save),
  .pg_wr_en(pg_wr_en), .pg_wr_sel(pg_wr_sel), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .rsp_valid(rsp_valid),
  .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr)
);

// File: tb/sram_page_cursor_test.sv
`timescale 1ns/1ps
module sram_page_cursor_test;
  localparam int UNITS = 1;
  localparam int MEM   = UNITS * 131072;
  localparam int LASTA = MEM - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic power_save, pg_wr_en, pg_wr_sel, pg_rd_sel;
  logic [7:0] pg_wr_data, pg_rd_data;
  logic req_valid, req_ready, req_write;
  logic [7:0] req_wdata, rsp_rdata;
  logic rsp_valid, sram_en, sram_we;
  logic [20:0] sram_addr;
  logic [7:0] sram_wdata, sram_rdata;

  always #2.5 clk = ~clk;

  sram_page_cursor #(.SIZE_UNITS(UNITS)) uut (
    .clk(clk), .rst_n(rst_n), .power_save(power_save),
    .pg_wr_en(pg_wr_en), .pg_wr_sel(pg_wr_sel), .pg_wr_data(pg_wr_data),
    .pg_rd_sel(pg_rd_sel), .pg_rd_data(pg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // external SRAM model driven only by the pins
  byte unsigned sram_mem [int];
  logic [7:0] rd_q;
  always @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) sram_mem[int'(sram_addr)] = sram_wdata;
      else rd_q <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 8'h00;
    end
  end
  assign sram_rdata = rd_q;

  // bench expectation model
  byte unsigned exp_mem [int];
  int m_ptr;
  int m_hi;
  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  function automatic int exp_byte(int a);
    return exp_mem.exists(a) ? int'(exp_mem[a]) : 0;
  endfunction

  function automatic int next_ptr(int p);
    return (p == LASTA) ? 0 : p + 1;
  endfunction

  function automatic int load_ptr(int hi, int lo);
    return ((hi * 256 + lo) * 32) % MEM;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic page_check(string tag);
    pg_rd_sel = 1'b0; #1;
    chk(tag, int'(pg_rd_data), (m_ptr >> 5) & 8'hff);
    pg_rd_sel = 1'b1; #1;
    chk(tag, int'(pg_rd_data), (m_ptr >> 13) & 8'hff);
    chk(tag, int'(sram_addr), m_ptr);
  endtask

  task automatic page_wr(bit hi, int d, string tag);
    @(negedge clk);
    pg_wr_en = 1'b1; pg_wr_sel = hi; pg_wr_data = 8'(d);
    #1;
    if (!hi) chk("R3 stall", int'(req_ready), 0);
    @(posedge clk);
    if (hi) m_hi = d; else m_ptr = load_ptr(m_hi, d);
    @(negedge clk);
    pg_wr_en = 1'b0;
    page_check(tag);
  endtask

  task automatic access(bit wr, int d, bit ps);
    int expd;
    bit en_exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = 8'(d); power_save = ps;
    #1;
    en_exp = !(wr && ps);
    chk(wr ? (ps ? "R9 en" : "R8 en") : "R7 en", int'(sram_en), int'(en_exp));
    chk("R4 addr", int'(sram_addr), m_ptr);
    if (wr && !ps) begin
      chk("R8 we", int'(sram_we), 1);
      chk("R8 wdata", int'(sram_wdata), d);
    end
    if (!wr) chk("R7 we", int'(sram_we), 0);
    expd = exp_byte(m_ptr);
    @(posedge clk);
    if (wr && !ps) exp_mem[m_ptr] = 8'(d);
    m_ptr = next_ptr(m_ptr);
    @(negedge clk);
    req_valid = 1'b0; power_save = 1'b0;
    #1;
    if (!wr) begin
      chk("R7 rsp_valid", int'(rsp_valid), 1);
      chk("R7 rdata", int'(rsp_rdata), expd);
    end
  endtask

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; power_save = 1'b0; pg_wr_en = 1'b0; pg_wr_sel = 1'b0;
    pg_wr_data = '0; pg_rd_sel = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_wdata = '0;
    m_ptr = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 sram_en", int'(sram_en), 0);
    page_check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle", int'(sram_en), 0);

    // R2: high byte alone does not move the cursor
    page_wr(1'b1, 8'h03, "R2");
    // R3: low byte loads page 0x0310 offset 0
    page_wr(1'b0, 8'h10, "R3");
    chk("R3 addr", int'(sram_addr), 32'h6200);

    // R8/R5: 40 writes cross into page 0x311
    for (int i = 0; i < 40; i++) access(1'b1, (i * 7 + 3) & 8'hff, 1'b0);
    page_check("R5 cross");
    chk("R5 page", m_ptr >> 5, 32'h311);

    // R7/R4: reload and read the same bytes back
    page_wr(1'b0, 8'h10, "R3 reload");
    for (int i = 0; i < 40; i++) access(1'b0, 0, 1'b0);

    // R9: power-save writes dropped but cursor advances
    page_wr(1'b0, 8'h10, "R3 reload");
    for (int i = 0; i < 3; i++) access(1'b1, 8'hee, 1'b1);
    page_check("R9 advance");
    access(1'b0, 0, 1'b1);
    page_wr(1'b0, 8'h10, "R3 reload");
    for (int i = 0; i < 4; i++) access(1'b0, 0, 1'b0);

    // R10: page 0x1234 reduced modulo the size
    page_wr(1'b1, 8'h12, "R2");
    page_wr(1'b0, 8'h34, "R10");
    chk("R10 addr", int'(sram_addr), 32'h234 * 32);

    // R6: last page, run past the end
    page_wr(1'b1, 8'h0f, "R2");
    page_wr(1'b0, 8'hff, "R6 load");
    for (int i = 0; i < 32; i++) access(1'b1, 8'h80 + i, 1'b0);
    chk("R6 wrap", int'(sram_addr), 0);
    page_check("R6");
    access(1'b0, 0, 1'b0);
    page_wr(1'b0, 8'hff, "R6 load");
    for (int i = 0; i < 32; i++) access(1'b0, 0, 1'b0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      r = int'($urandom_range(0, 99));
      if (r < 6)       page_wr(1'b1, int'($urandom_range(0, 255)), "R2 rnd");
      else if (r < 14) page_wr(1'b0, int'($urandom_range(0, 255)), "R3 rnd");
      else if (r < 55) access(1'b1, int'($urandom_range(0, 255)), ($urandom_range(0, 9) == 0));
      else             access(1'b0, 0, ($urandom_range(0, 4) == 0));
    end
    page_check("R5 rnd");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule